// File: doc/BRIEF.md
# SCL Clock Divider Generator

This block derives the serial-clock timing for a two-wire bus controller from a fast peripheral clock. A prescaler divides the peripheral clock by one plus a small divide field and yields a one-cycle internal tick. A period counter advances on those ticks. It splits every SCL period into a low phase and a high phase. It also raises two strobes for the bit engine: one in the middle of the low phase, where data may change, and one in the middle of the high phase, where data is sampled.

All timing comes from one configuration word. The SCL period in internal ticks is 20 plus eight times a 6-bit stretch field plus a compensation count. The compensation count covers edge rise, edge fall and internal delay. It arrives on its own input and is captured whenever a configuration takes effect. The divider stays quiet after reset until the first configuration write. A write made while the controller reports a transfer in progress is held back. It is applied at the first period boundary after the controller goes idle.

Top module: `scl_clkdiv`

## Requirements
- R1: The internal tick `ick_en_o` is high for one peripheral-clock cycle in every (CDF+1) cycles, so one SCL period lasts (CDF+1)·P peripheral clocks and holds exactly P ticks.
- R2: The SCL period P, counted in internal ticks, is 20 + 8·SCGD + COMP, where COMP is the value of `comp_i` captured when the configuration took effect.
- R3: `scl_low_o` is high for the first ceil(P/2) ticks of each period and low for the remaining floor(P/2) ticks.
- R4: With L = ceil(P/2) and H = P − L, `chg_stb_o` pulses on the tick at index floor(L/2) and `smp_stb_o` pulses on the tick at index L + floor(H/2), where tick 0 is the first tick of the period. The two strobes are never high together. The change strobe falls inside the low phase and the sample strobe falls inside the high phase.
- R5: The configuration word packs CDF in bits [CDF_W−1:0] and SCGD in bits [CDF_W+5:CDF_W], where CDF_W is 2 or 3 and is set by a parameter.
- R6: From reset until the first configuration write, `scl_low_o`, `ick_en_o`, `chg_stb_o` and `smp_stb_o` all stay low.
- R7: While `busy_i` is high, a configuration write does not change the running period. The write takes effect at the first period boundary at which `busy_i` is low.
- R8: Changes on `comp_i` between configuration applications have no effect on the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CDF_W+6 | Configuration word, SCGD above CDF |
| comp_i | input | 8 | Edge and delay compensation count |
| busy_i | input | 1 | Transfer in progress, which defers configuration changes |
| ick_en_o | output | 1 | Internal clock tick |
| scl_low_o | output | 1 | SCL drive-low request |
| chg_stb_o | output | 1 | Data-change strobe at mid low phase |
| smp_stb_o | output | 1 | Sample strobe at mid high phase |

## Verification
The hardest case to reach is a configuration write that lands while a transfer is in progress. It must stay invisible for as long as `busy_i` holds, and it must then take effect only at a period boundary. The bench first runs one setting. It raises `busy_i`, writes a different setting and measures a full period to confirm the old timing still holds. It then drops `busy_i` and measures again to confirm the new timing. The bench measures every period between two change strobes. Its results therefore do not depend on which cycle the boundary happens to fall in.

// File: rtl/scl_clkdiv_pkg.sv
package scl_clkdiv_pkg;

    localparam int SCGD_W     = 6;   // stretch field width
    localparam int CDF_MAX_W  = 3;   // widest supported prescale field
    localparam int COMP_W     = 8;   // compensation count width
    localparam int PER_W      = 10;  // holds 20 + 8*63 + 255
    localparam int BASE_CYC   = 20;  // fixed part of the period
    localparam int SCGD_SHIFT = 3;   // stretch step of eight ticks

    typedef struct packed {
        logic [CDF_MAX_W-1:0] cdf;
        logic [SCGD_W-1:0]    scgd;
        logic [COMP_W-1:0]    comp;
    } div_cfg_t;

    function automatic logic [PER_W-1:0] period_of(div_cfg_t c);
        return PER_W'(BASE_CYC) + (PER_W'(c.scgd) << SCGD_SHIFT) + PER_W'(c.comp);
    endfunction

endpackage

// File: rtl/scl_clkdiv_cfg.sv
module scl_clkdiv_cfg
    import scl_clkdiv_pkg::*;
#(
    parameter int CDF_W = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_i,
    input  logic [CDF_W+SCGD_W-1:0] wdata_i,
    input  logic [COMP_W-1:0]       comp_i,
    input  logic                    busy_i,
    input  logic                    wrap_i,
    output div_cfg_t                act_o,
    output logic                    run_o,
    output logic                    restart_o
);

    localparam int CW = CDF_W + SCGD_W;

    typedef struct packed {
        logic [CW-1:0] shadow;
        logic          pend;
        div_cfg_t      act;
        logic          run;
    } cfg_st_t;

    cfg_st_t q, d;
    logic [CDF_MAX_W-1:0] cdf_ext;
    logic                 apply;

    // Zero-extend the prescale field to the widest supported layout.
    generate
        if (CDF_W < CDF_MAX_W) begin : g_cdf_pad
            assign cdf_ext = {{(CDF_MAX_W-CDF_W){1'b0}}, q.shadow[CDF_W-1:0]};
        end else begin : g_cdf_full
            assign cdf_ext = q.shadow[CDF_MAX_W-1:0];
        end
    endgenerate

    always_comb begin
        d     = q;
        apply = q.pend && !busy_i && (!q.run || wrap_i);
        if (apply) begin
            d.act.cdf  = cdf_ext;
            d.act.scgd = q.shadow[CW-1:CDF_W];
            d.act.comp = comp_i;
            d.run      = 1'b1;
            d.pend     = 1'b0;
        end
        if (wr_i) begin
            d.shadow = wdata_i;
            d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign act_o     = q.act;
    assign run_o     = q.run;
    assign restart_o = apply;

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> $stable(q.act)); // R7
    AST_START_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.run) |-> $past(q.pend)); // R6

endmodule

// File: rtl/scl_clkdiv_presc.sv
module scl_clkdiv_presc
    import scl_clkdiv_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic                 restart_i,
    input  logic [CDF_MAX_W-1:0] cdf_i,
    output logic                 ick_en_o
);

    typedef struct packed {
        logic [CDF_MAX_W-1:0] pre;
    } pre_st_t;

    pre_st_t q, d;
    logic    tick;

    always_comb begin
        d    = q;
        tick = run_i && (q.pre == cdf_i);
        if (!run_i || restart_i || tick) begin
            d.pre = '0;
        end else begin
            d.pre = q.pre + CDF_MAX_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ick_en_o = tick;

    AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && !restart_i |-> q.pre <= cdf_i); // R1
    AST_TICK_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick && !restart_i |=> q.pre == '0); // R1

endmodule

// File: rtl/scl_clkdiv_phase.sv
module scl_clkdiv_phase
    import scl_clkdiv_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     run_i,
    input  logic     restart_i,
    input  logic     ick_i,
    input  div_cfg_t cfg_i,
    output logic     scl_low_o,
    output logic     chg_o,
    output logic     smp_o,
    output logic     wrap_o
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } ph_st_t;

    ph_st_t           q, d;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] low_len;
    logic [PER_W-1:0] high_len;
    logic [PER_W-1:0] chg_pt;
    logic [PER_W-1:0] smp_pt;
    logic             last;

    always_comb begin
        period   = period_of(cfg_i);
        low_len  = (period + PER_W'(1)) >> 1;
        high_len = period - low_len;
        chg_pt   = low_len >> 1;
        smp_pt   = low_len + (high_len >> 1);
        last     = ick_i && (q.cnt == period - PER_W'(1));

        d = q;
        if (!run_i || restart_i || last) begin
            d.cnt = '0;
        end else if (ick_i) begin
            d.cnt = q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign scl_low_o = run_i && (q.cnt < low_len);
    assign chg_o     = ick_i && (q.cnt == chg_pt);
    assign smp_o     = ick_i && (q.cnt == smp_pt);
    assign wrap_o    = last;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt < period_of(cfg_i)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(chg_o && smp_o)); // R4
    AST_CHG_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg_o |-> scl_low_o); // R4
    AST_SMP_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_o |-> !scl_low_o); // R4

endmodule

// File: rtl/scl_clkdiv.sv
module scl_clkdiv
    import scl_clkdiv_pkg::*;
#(
    parameter int CDF_W = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cfg_wr_i,
    input  logic [CDF_W+SCGD_W-1:0] cfg_wdata_i,
    input  logic [COMP_W-1:0]       comp_i,
    input  logic                    busy_i,
    output logic                    ick_en_o,
    output logic                    scl_low_o,
    output logic                    chg_stb_o,
    output logic                    smp_stb_o
);

    div_cfg_t act;
    logic     run;
    logic     restart;
    logic     wrap;
    logic     ick;

    scl_clkdiv_cfg #(.CDF_W(CDF_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cfg_wr_i),
        .wdata_i   (cfg_wdata_i),
        .comp_i    (comp_i),
        .busy_i    (busy_i),
        .wrap_i    (wrap),
        .act_o     (act),
        .run_o     (run),
        .restart_o (restart)
    );

    scl_clkdiv_presc u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (restart),
        .cdf_i     (act.cdf),
        .ick_en_o  (ick)
    );

    scl_clkdiv_phase u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (restart),
        .ick_i     (ick),
        .cfg_i     (act),
        .scl_low_o (scl_low_o),
        .chg_o     (chg_stb_o),
        .smp_o     (smp_stb_o),
        .wrap_o    (wrap)
    );

    assign ick_en_o = ick;

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |-> !scl_low_o && !ick_en_o && !chg_stb_o && !smp_stb_o); // R6
    AST_STB_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_stb_o || smp_stb_o) |-> ick_en_o); // R1

endmodule

// File: tb/scl_clkdiv_test.sv
module scl_clkdiv_test;

    localparam int CLK_PERIOD = 10;
    localparam int CDF_W      = 3;
    localparam int WDOG_LIMIT = 190000;
    localparam int NVEC       = 8;
    // columns: cdf, scgd, comp
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 0}, '{1, 0, 1}, '{3, 2, 6}, '{7, 1, 3},
        '{2, 63, 255}, '{0, 5, 0}, '{4, 10, 7}, '{7, 63, 255}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_wr = 1'b0;
    logic [CDF_W+5:0]    cfg_wdata = '0;
    logic [7:0]          comp = '0;
    logic                busy = 1'b0;
    logic                ick_en, scl_low, chg_stb, smp_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    scl_clkdiv #(.CDF_W(CDF_W)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_wdata_i (cfg_wdata),
        .comp_i      (comp),
        .busy_i      (busy),
        .ick_en_o    (ick_en),
        .scl_low_o   (scl_low),
        .chg_stb_o   (chg_stb),
        .smp_stb_o   (smp_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act cycles=%0d exp below %0d", cycles, WDOG_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // R5: word = {SCGD, CDF}
    task automatic write_cfg(input int c, input int s);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = {6'(s), CDF_W'(c)};
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic next_chg();
        do @(negedge clk); while (!chg_stb);
    endtask

    // Skip two change strobes, then measure one full period.
    task automatic measure(output int nclk, output int nlow, output int nick, output int sdist);
        next_chg();
        next_chg();
        nclk = 0; nlow = 0; nick = 0; sdist = -1;
        do begin
            @(negedge clk);
            nclk = nclk + 1;
            if (scl_low) nlow = nlow + 1;
            if (ick_en)  nick = nick + 1;
            if (smp_stb) sdist = nclk;
        end while (!chg_stb);
    endtask

    task automatic check_timing(input string tag, input int c, input int s, input int r);
        int nclk, nlow, nick, sdist, p, l, h;
        p = 20 + 8 * s + r;
        l = (p + 1) / 2;
        h = p - l;
        measure(nclk, nlow, nick, sdist);
        check({tag, " R1 R5 period clocks"}, nclk, (c + 1) * p);
        check({tag, " R2 ticks per period"}, nick, p);
        check({tag, " R3 low clocks"}, nlow, (c + 1) * l);
        check({tag, " R4 change-to-sample"}, sdist, (c + 1) * (l + h / 2 - l / 2));
    endtask

    initial begin
        int quiet;
        // R6: reset state and quiet until first write
        repeat (4) @(negedge clk);
        check("R6 reset scl_low", int'(scl_low), 0);
        check("R6 reset ick_en", int'(ick_en), 0);
        rst_n = 1'b1;
        quiet = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (scl_low || ick_en || chg_stb || smp_stb) quiet = quiet + 1;
        end
        check("R6 outputs before first write", quiet, 0);

        // table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            comp = 8'(VEC[v][2]);
            write_cfg(VEC[v][0], VEC[v][1]);
            check_timing($sformatf("vec%0d", v), VEC[v][0], VEC[v][1], VEC[v][2]);
        end

        // R7: write while busy is deferred
        comp = 8'd4;
        write_cfg(1, 2);
        check_timing("R7 base", 1, 2, 4);
        busy = 1'b1;
        comp = 8'd0;
        write_cfg(0, 0);
        check_timing("R7 held while busy", 1, 2, 4);
        check_timing("R7 still held", 1, 2, 4);
        @(negedge clk);
        busy = 1'b0;
        check_timing("R7 applied after idle", 0, 0, 0);

        // R8: comp changes outside application are ignored
        comp = 8'd10;
        write_cfg(0, 1);
        check_timing("R8 base", 0, 1, 10);
        comp = 8'd200;
        check_timing("R8 comp change ignored", 0, 1, 10);
        write_cfg(0, 1);
        check_timing("R8 new comp on apply", 0, 1, 200);

        // R5: narrow odd period with top CDF bit only
        comp = 8'd1;
        write_cfg(4, 0);
        check_timing("R5 cdf msb", 4, 0, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule